// File: doc/BRIEF.md
# In-Order Multi-Retire Commit Tracker

This block follows in-flight instructions from issue to commit. A front end allocates one to several entries per cycle in program order into a circular tracker. Execution units mark entries complete in any order, each completion carrying an exception flag and a branch-mispredict flag. Each cycle the block commits, in program order, the longest unbroken run of finished, fault-free entries starting at the oldest entry, with at most eleven per cycle.

When that run ends at an entry that has finished but carries a fault, the block raises a flush that names the faulting entry. The older entries ahead of it still commit in the same cycle. The faulting entry and everything younger are discarded, so the tracker is empty on the next cycle. Register renaming, memory ordering and the actual architectural updates belong to the consumers of the commit outputs.

Top module: `inorder_commit_unit`

## Requirements
- R1: Out of reset the tracker is empty: occupancy 0, retire_cnt 0, commit_valid all zero, flush 0, and an allocation request is accepted.
- R2: A request for n entries is accepted (alloc_ok=1) exactly when DEPTH minus occupancy is at least n and no flush is active. An accepted request's first entry is alloc_base_idx and occupancy grows by n on the next cycle. A refused request leaves occupancy and alloc_base_idx unchanged.
- R3: Head and tail pointers carry one wrap bit above the index, so a full tracker (occupancy equal to DEPTH) is told apart from an empty one. When full, every nonzero request is refused, and indices wrap from DEPTH-1 to 0.
- R4: A completion on port p (cmpl_valid[p]=1, entry index in cmpl_idx bits p*IDX_W and up) marks that entry done, together with its exception and mispredict flags. The new state counts in the retire decision from the following cycle.
- R5: An entry commits only if every older entry has finished clean. An unfinished entry blocks all younger finished entries.
- R6: retire_cnt equals the number of consecutive finished, fault-free entries starting at the head, capped at RET_MAX. commit_valid bit k is 1 for k < retire_cnt and 0 otherwise. retire_head_idx is the index of commit slot 0. The head moves forward by retire_cnt on the next edge.
- R7: If the entry just past the committing run is finished and flagged, flush is 1 and flush_idx is that entry's index, while the run before it still commits. On the next cycle occupancy is 0, and the head and the tail both sit at the flushed index.
- R8: No allocation is accepted in a flush cycle.
- R9: An exception flag and a mispredict flag each stop commit and raise flush in the same way, including when the flagged entry is at the head (retire_cnt 0).
- R10: When the first eleven entries are clean and the twelfth is flagged, the cycle commits eleven with no flush, and the next cycle raises flush on the flagged entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | $clog2(ALLOC_W+1) | Number of entries requested this cycle |
| alloc_ok | output | 1 | Request accepted |
| alloc_base_idx | output | $clog2(DEPTH) | Index given to the first allocated entry |
| cmpl_valid | input | CMPL_W | Completion valid per port |
| cmpl_idx | input | CMPL_W*$clog2(DEPTH) | Completed entry index per port |
| cmpl_exc | input | CMPL_W | Exception flag per port |
| cmpl_misp | input | CMPL_W | Mispredict flag per port |
| retire_cnt | output | $clog2(RET_MAX+1) | Entries committing this cycle |
| commit_valid | output | RET_MAX | Thermometer mask of committing slots |
| retire_head_idx | output | $clog2(DEPTH) | Index of commit slot 0 (oldest entry) |
| flush | output | 1 | Faulting entry reached; squash it and all younger |
| flush_idx | output | $clog2(DEPTH) | Index of the faulting entry |
| occupancy | output | $clog2(DEPTH)+1 | Entries currently held |

## Verification
The bench builds the tracker with DEPTH=16, RET_MAX=11, ALLOC_W=4 and CMPL_W=4. With only sixteen entries, four four-wide allocations fill the tracker, which exercises the full-versus-empty wrap bit and the refusal of a request. A later group of twelve entries runs across the index wrap from 15 to 0. Sixteen outstanding entries leave room for more than eleven finished entries, so the eleven-wide cap and the case of a fault sitting just past the cap are both reached in short directed sequences.

// File: rtl/commit_pkg.sv
package commit_pkg;

  // Distance from b forward to a on a ring of the given size.
  function automatic int ring_gap(input int a, input int b, input int modulus);
    return (a - b + modulus) % modulus;
  endfunction

  // Position n steps forward of a on a ring of the given size.
  function automatic int ring_step(input int a, input int n, input int modulus);
    return (a + n) % modulus;
  endfunction

  // An entry is clean when it has finished and raised no fault.
  function automatic logic entry_clean(input logic done, input logic exc, input logic misp);
    return done & ~exc & ~misp;
  endfunction

  // An entry blocks with a flush when it has finished and raised a fault.
  function automatic logic entry_fault(input logic done, input logic exc, input logic misp);
    return done & (exc | misp);
  endfunction

endpackage

// File: rtl/commit_ptr_ctrl.sv
module commit_ptr_ctrl
  import commit_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int ALLOC_W = 4,
  parameter int RET_MAX = 11,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int AREQ_W = $clog2(ALLOC_W + 1),
  localparam int RCNT_W = $clog2(RET_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AREQ_W-1:0] alloc_req,
  input  logic [RCNT_W-1:0] retire_cnt,
  input  logic              flush,
  output logic [PTR_W-1:0]  head_ptr,
  output logic [PTR_W-1:0]  tail_ptr,
  output logic [PTR_W-1:0]  fill,
  output logic              alloc_ok
);

  localparam int PTR_MOD = 2 * DEPTH;

  logic [PTR_W-1:0] head_nxt;
  logic [PTR_W-1:0] tail_alloc;
  int               free_slots;

  assign fill       = PTR_W'(ring_gap(int'(tail_ptr), int'(head_ptr), PTR_MOD));
  assign free_slots = DEPTH - int'(fill);
  assign alloc_ok   = ~flush && (free_slots >= int'(alloc_req));
  assign head_nxt   = PTR_W'(ring_step(int'(head_ptr), int'(retire_cnt), PTR_MOD));
  assign tail_alloc = PTR_W'(ring_step(int'(tail_ptr), int'(alloc_req), PTR_MOD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      head_ptr <= head_nxt;
      if (flush)         tail_ptr <= head_nxt;
      else if (alloc_ok) tail_ptr <= tail_alloc;
    end
  end

  // The wrap bit must keep occupancy within the tracker size.
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  // A flush leaves the tracker empty on the following cycle.
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0));

  // A refused request leaves the tail where it was.
  assert_refuse_holds_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ok && !flush) |=> (tail_ptr == $past(tail_ptr)));

endmodule

// File: rtl/commit_entry_array.sv
module commit_entry_array
  import commit_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int ALLOC_W = 4,
  parameter int CMPL_W  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int AREQ_W = $clog2(ALLOC_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_fire,
  input  logic [IDX_W-1:0]        alloc_base,
  input  logic [AREQ_W-1:0]       alloc_req,
  input  logic [CMPL_W-1:0]       cmpl_valid,
  input  logic [CMPL_W*IDX_W-1:0] cmpl_idx,
  input  logic [CMPL_W-1:0]       cmpl_exc,
  input  logic [CMPL_W-1:0]       cmpl_misp,
  output logic [DEPTH-1:0]        done_q,
  output logic [DEPTH-1:0]        exc_q,
  output logic [DEPTH-1:0]        misp_q
);

  logic [DEPTH-1:0] alloc_hit;
  logic [DEPTH-1:0] cmpl_hit;
  logic [DEPTH-1:0] cmpl_exc_in;
  logic [DEPTH-1:0] cmpl_misp_in;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit_c, exc_c, misp_c;

    // Entry lies inside this cycle's allocation window.
    assign alloc_hit[e] = alloc_fire &&
      (ring_gap(e, int'(alloc_base), DEPTH) < int'(alloc_req));

    // Merge all completion ports that name this entry.
    always_comb begin
      hit_c  = 1'b0;
      exc_c  = 1'b0;
      misp_c = 1'b0;
      for (int p = 0; p < CMPL_W; p++) begin
        if (cmpl_valid[p] && (cmpl_idx[p*IDX_W +: IDX_W] == IDX_W'(e))) begin
          hit_c  = 1'b1;
          exc_c  = exc_c  | cmpl_exc[p];
          misp_c = misp_c | cmpl_misp[p];
        end
      end
    end

    assign cmpl_hit[e]     = hit_c;
    assign cmpl_exc_in[e]  = exc_c;
    assign cmpl_misp_in[e] = misp_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
      exc_q  <= '0;
      misp_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_hit[e]) begin
          done_q[e] <= 1'b0;
          exc_q[e]  <= 1'b0;
          misp_q[e] <= 1'b0;
        end else if (cmpl_hit[e]) begin
          done_q[e] <= 1'b1;
          exc_q[e]  <= cmpl_exc_in[e];
          misp_q[e] <= cmpl_misp_in[e];
        end
      end
    end
  end

  // Allocation writes never overlap more entries than the request size.
  assert_alloc_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(alloc_hit) <= int'(alloc_req));

endmodule

// File: rtl/commit_retire_scan.sv
module commit_retire_scan
  import commit_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int RET_MAX = 11,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int RCNT_W = $clog2(RET_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   head_idx,
  input  logic [PTR_W-1:0]   fill,
  input  logic [DEPTH-1:0]   done_q,
  input  logic [DEPTH-1:0]   exc_q,
  input  logic [DEPTH-1:0]   misp_q,
  output logic [RET_MAX-1:0] commit_valid,
  output logic [RCNT_W-1:0]  retire_cnt,
  output logic               flush,
  output logic [IDX_W-1:0]   flush_idx
);

  logic [IDX_W-1:0]   slot_idx [RET_MAX];
  logic [RET_MAX-1:0] slot_live;
  logic [RET_MAX-1:0] slot_clean;
  logic [RET_MAX-1:0] slot_fault;
  logic [RET_MAX-1:0] run_chain;

  for (genvar k = 0; k < RET_MAX; k++) begin : g_slot
    assign slot_idx[k]   = IDX_W'(ring_step(int'(head_idx), k, DEPTH));
    assign slot_live[k]  = int'(fill) > k;
    assign slot_clean[k] = slot_live[k] &
      entry_clean(done_q[slot_idx[k]], exc_q[slot_idx[k]], misp_q[slot_idx[k]]);
    assign slot_fault[k] = slot_live[k] &
      entry_fault(done_q[slot_idx[k]], exc_q[slot_idx[k]], misp_q[slot_idx[k]]);
    if (k == 0) begin : g_first
      assign run_chain[k] = slot_clean[k];
    end else begin : g_next
      assign run_chain[k] = run_chain[k-1] & slot_clean[k];
    end
  end

  assign commit_valid = run_chain;

  // Count of the clean run, found by scanning for the first break.
  always_comb begin
    logic stop;
    stop       = 1'b0;
    retire_cnt = '0;
    for (int k = 0; k < RET_MAX; k++) begin
      if (!stop) begin
        if (slot_clean[k]) retire_cnt = retire_cnt + 1'b1;
        else               stop = 1'b1;
      end
    end
  end

  // The slot where the run broke decides whether to flush.
  always_comb begin
    flush     = 1'b0;
    flush_idx = '0;
    for (int k = 0; k < RET_MAX; k++) begin
      if ((int'(retire_cnt) == k) && slot_fault[k]) begin
        flush     = 1'b1;
        flush_idx = slot_idx[k];
      end
    end
  end

  // Mask and count are built separately and must agree.
  assert_mask_matches_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(commit_valid) == int'(retire_cnt));

  // Committing slots form a prefix starting at slot 0.
  assert_mask_is_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, commit_valid} + 1'b1) & {1'b0, commit_valid}) == '0);

  // Never more than the per-cycle cap.
  assert_retire_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_cnt) <= RET_MAX);

  // A flush names a slot inside the window, so the run fell short of the cap.
  assert_flush_below_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (int'(retire_cnt) < RET_MAX));

endmodule

// File: rtl/inorder_commit_unit.sv
module inorder_commit_unit
  import commit_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int RET_MAX = 11,
  parameter int ALLOC_W = 4,
  parameter int CMPL_W  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int AREQ_W = $clog2(ALLOC_W + 1),
  localparam int RCNT_W = $clog2(RET_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AREQ_W-1:0]       alloc_req,
  output logic                    alloc_ok,
  output logic [IDX_W-1:0]        alloc_base_idx,
  input  logic [CMPL_W-1:0]       cmpl_valid,
  input  logic [CMPL_W*IDX_W-1:0] cmpl_idx,
  input  logic [CMPL_W-1:0]       cmpl_exc,
  input  logic [CMPL_W-1:0]       cmpl_misp,
  output logic [RCNT_W-1:0]       retire_cnt,
  output logic [RET_MAX-1:0]      commit_valid,
  output logic [IDX_W-1:0]        retire_head_idx,
  output logic                    flush,
  output logic [IDX_W-1:0]        flush_idx,
  output logic [PTR_W-1:0]        occupancy
);

  logic [PTR_W-1:0] head_ptr;
  logic [PTR_W-1:0] tail_ptr;
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] exc_q;
  logic [DEPTH-1:0] misp_q;

  commit_ptr_ctrl #(
    .DEPTH   (DEPTH),
    .ALLOC_W (ALLOC_W),
    .RET_MAX (RET_MAX)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .retire_cnt (retire_cnt),
    .flush      (flush),
    .head_ptr   (head_ptr),
    .tail_ptr   (tail_ptr),
    .fill       (occupancy),
    .alloc_ok   (alloc_ok)
  );

  commit_entry_array #(
    .DEPTH   (DEPTH),
    .ALLOC_W (ALLOC_W),
    .CMPL_W  (CMPL_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_ok),
    .alloc_base (alloc_base_idx),
    .alloc_req  (alloc_req),
    .cmpl_valid (cmpl_valid),
    .cmpl_idx   (cmpl_idx),
    .cmpl_exc   (cmpl_exc),
    .cmpl_misp  (cmpl_misp),
    .done_q     (done_q),
    .exc_q      (exc_q),
    .misp_q     (misp_q)
  );

  commit_retire_scan #(
    .DEPTH   (DEPTH),
    .RET_MAX (RET_MAX)
  ) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_idx     (retire_head_idx),
    .fill         (occupancy),
    .done_q       (done_q),
    .exc_q        (exc_q),
    .misp_q       (misp_q),
    .commit_valid (commit_valid),
    .retire_cnt   (retire_cnt),
    .flush        (flush),
    .flush_idx    (flush_idx)
  );

  assign retire_head_idx = head_ptr[IDX_W-1:0];
  assign alloc_base_idx  = tail_ptr[IDX_W-1:0];

  // Commit never runs past the entries actually held.
  assert_retire_within_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_cnt) <= int'(occupancy));

  // Pointer control and scan agree: no allocation while flushing.
  assert_no_alloc_on_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ok);

  // A flushed index becomes both head and tail on the next cycle.
  assert_flush_repoints_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (retire_head_idx == $past(flush_idx)) && (alloc_base_idx == $past(flush_idx)));

endmodule

// File: tb/sim_inorder_commit_unit.sv
`timescale 1ns/1ps
module sim_inorder_commit_unit;

  localparam int DEPTH = 16;
  localparam int RMAX  = 11;
  localparam int AW    = 4;
  localparam int CW    = 4;
  localparam int IW    = $clog2(DEPTH);
  localparam int AQW   = $clog2(AW + 1);
  localparam int RCW   = $clog2(RMAX + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AQW-1:0]  alloc_req = '0;
  logic            alloc_ok;
  logic [IW-1:0]   alloc_base_idx;
  logic [CW-1:0]   cmpl_valid = '0;
  logic [CW*IW-1:0] cmpl_idx = '0;
  logic [CW-1:0]   cmpl_exc = '0;
  logic [CW-1:0]   cmpl_misp = '0;
  logic [RCW-1:0]  retire_cnt;
  logic [RMAX-1:0] commit_valid;
  logic [IW-1:0]   retire_head_idx;
  logic            flush;
  logic [IW-1:0]   flush_idx;
  logic [IW:0]     occupancy;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  inorder_commit_unit #(
    .DEPTH(DEPTH), .RET_MAX(RMAX), .ALLOC_W(AW), .CMPL_W(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_base_idx(alloc_base_idx),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_exc(cmpl_exc), .cmpl_misp(cmpl_misp),
    .retire_cnt(retire_cnt), .commit_valid(commit_valid), .retire_head_idx(retire_head_idx),
    .flush(flush), .flush_idx(flush_idx), .occupancy(occupancy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Move to the next negative edge and drop all stimulus.
  task automatic next_cyc();
    @(negedge clk);
    alloc_req  = '0;
    cmpl_valid = '0;
    cmpl_idx   = '0;
    cmpl_exc   = '0;
    cmpl_misp  = '0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic put_cmpl(input int p, input int idx, input bit exc, input bit misp);
    cmpl_valid[p]          = 1'b1;
    cmpl_idx[p*IW +: IW]   = IW'(idx);
    cmpl_exc[p]            = exc;
    cmpl_misp[p]           = misp;
  endtask

  task automatic do_alloc(input int n, input int exp_base, input string tag);
    next_cyc();
    alloc_req = AQW'(n);
    settle();
    chk({tag, " alloc_ok"}, int'(alloc_ok), 1);
    chk({tag, " base"}, int'(alloc_base_idx), exp_base);
  endtask

  // R1 and start of in-order blocking scenario (R2 R4 R5 R6)
  task automatic t_order_block();
    next_cyc();
    alloc_req = 3'd4;
    settle();
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 retire_cnt", int'(retire_cnt), 0);
    chk("R1 commit_valid", int'(commit_valid), 0);
    chk("R1 flush", int'(flush), 0);
    chk("R1 alloc_ok", int'(alloc_ok), 1);
    chk("R2 base", int'(alloc_base_idx), 0);
    next_cyc();
    put_cmpl(0, 1, 0, 0); put_cmpl(1, 2, 0, 0); put_cmpl(2, 3, 0, 0);
    settle();
    chk("R2 occupancy grew", int'(occupancy), 4);
    chk("R5 nothing done yet", int'(retire_cnt), 0);
    next_cyc();
    put_cmpl(0, 0, 0, 0);
    settle();
    chk("R5 head unfinished blocks", int'(retire_cnt), 0);
    next_cyc();
    settle();
    chk("R4 R6 retire four", int'(retire_cnt), 4);
    chk("R6 mask", int'(commit_valid), 'hF);
    chk("R6 head idx", int'(retire_head_idx), 0);
    next_cyc();
    settle();
    chk("R6 empty after", int'(occupancy), 0);
    chk("R6 head moved", int'(retire_head_idx), 4);
  endtask

  // Full tracker, refusal, cap of eleven, wrap (R2 R3 R6 R10)
  task automatic t_full_and_cap();
    do_alloc(4, 4, "R3 a0");
    do_alloc(4, 8, "R3 a1");
    do_alloc(4, 12, "R3 a2");
    do_alloc(4, 0, "R3 wrap");
    next_cyc();
    alloc_req = 3'd1;
    settle();
    chk("R3 full occupancy", int'(occupancy), 16);
    chk("R3 full refuses", int'(alloc_ok), 0);
    next_cyc();
    for (int p = 0; p < 4; p++) put_cmpl(p, 8 + p, 0, 0);
    settle();
    chk("R2 refused keeps occupancy", int'(occupancy), 16);
    chk("R2 refused keeps base", int'(alloc_base_idx), 4);
    next_cyc();
    for (int p = 0; p < 4; p++) put_cmpl(p, 12 + p, 0, 0);
    next_cyc();
    for (int p = 0; p < 4; p++) put_cmpl(p, p, 0, 0);
    next_cyc();
    for (int p = 0; p < 4; p++) put_cmpl(p, 4 + p, 0, 0);
    settle();
    chk("R5 head unfinished", int'(retire_cnt), 0);
    next_cyc();
    settle();
    chk("R6 R10 capped at eleven", int'(retire_cnt), 11);
    chk("R6 cap mask", int'(commit_valid), 'h7FF);
    chk("R6 head idx", int'(retire_head_idx), 4);
    next_cyc();
    settle();
    chk("R6 remainder", int'(retire_cnt), 5);
    chk("R3 head idx wrapped slot", int'(retire_head_idx), 15);
    next_cyc();
    settle();
    chk("R3 empty after wrap", int'(occupancy), 0);
    chk("R3 head idx", int'(retire_head_idx), 4);
  endtask

  // Exception mid-run (R7 R8 R9)
  task automatic t_exc_flush();
    do_alloc(4, 4, "R7 alloc");
    next_cyc();
    put_cmpl(0, 4, 0, 0); put_cmpl(1, 5, 0, 0);
    put_cmpl(2, 6, 1, 0); put_cmpl(3, 7, 0, 0);
    next_cyc();
    alloc_req = 3'd2;
    settle();
    chk("R7 older commit", int'(retire_cnt), 2);
    chk("R7 mask", int'(commit_valid), 'h3);
    chk("R9 exc flush", int'(flush), 1);
    chk("R7 flush idx", int'(flush_idx), 6);
    chk("R8 alloc refused", int'(alloc_ok), 0);
    next_cyc();
    settle();
    chk("R7 empty", int'(occupancy), 0);
    chk("R7 head at flushed", int'(retire_head_idx), 6);
    chk("R7 tail at flushed", int'(alloc_base_idx), 6);
    chk("R7 flush gone", int'(flush), 0);
  endtask

  // Mispredict at head (R9)
  task automatic t_misp_head();
    do_alloc(3, 6, "R9 alloc");
    next_cyc();
    put_cmpl(0, 6, 0, 1); put_cmpl(1, 7, 0, 0);
    next_cyc();
    settle();
    chk("R9 head misp retire", int'(retire_cnt), 0);
    chk("R9 misp flush", int'(flush), 1);
    chk("R9 flush idx", int'(flush_idx), 6);
    next_cyc();
    settle();
    chk("R9 empty", int'(occupancy), 0);
    chk("R9 head", int'(retire_head_idx), 6);
  endtask

  // Fault just beyond the cap (R10)
  task automatic t_fault_past_cap();
    do_alloc(4, 6, "R10 a0");
    do_alloc(4, 10, "R10 a1");
    do_alloc(4, 14, "R10 a2");
    next_cyc();
    put_cmpl(0, 1, 1, 0); put_cmpl(1, 0, 0, 0); put_cmpl(2, 15, 0, 0); put_cmpl(3, 14, 0, 0);
    settle();
    chk("R10 occupancy", int'(occupancy), 12);
    next_cyc();
    for (int p = 0; p < 4; p++) put_cmpl(p, 13 - p, 0, 0);
    next_cyc();
    for (int p = 0; p < 4; p++) put_cmpl(p, 9 - p, 0, 0);
    settle();
    chk("R10 head unfinished", int'(retire_cnt), 0);
    next_cyc();
    settle();
    chk("R10 eleven commit", int'(retire_cnt), 11);
    chk("R10 no flush yet", int'(flush), 0);
    next_cyc();
    settle();
    chk("R10 then nothing", int'(retire_cnt), 0);
    chk("R10 then flush", int'(flush), 1);
    chk("R10 flush idx", int'(flush_idx), 1);
    next_cyc();
    settle();
    chk("R10 empty", int'(occupancy), 0);
    chk("R10 head", int'(retire_head_idx), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_order_block();
    t_full_and_cap();
    t_exc_flush();
    t_misp_head();
    t_fault_past_cap();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule